// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This unit keeps the three host-visible bytes that describe the state of a SCSI controller: the status byte (bus phase, terminal-count flag, two error flags and the interrupt flag), the interrupt-reason byte and the sequence-step byte. It also keeps a configuration byte that comes out of reset with a fixed value. The command logic around it loads the bus phase, sets terminal-count and error flags, ORs in interrupt reasons, loads the sequence step and raises the interrupt. The unit drives a level interrupt line that always matches the status interrupt flag.

The host reads the four bytes through a small select port. Three of those reads are free of side effects. A read of the interrupt-reason byte returns its current value. On the next clock edge it zeroes the reasons and clears the interrupt flag and the error flags in the status byte, so the interrupt line drops. The bus phase, the terminal-count flag and the sequence step are kept across that read.

A set request that lands in the same cycle as a clearing read takes priority, so a reason or a raise is never lost.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset the status, reason and sequence-step bytes read 0x00, the configuration byte reads 0x07 and `irqOut` is low.
- R2: A phase load replaces status bits 2:0 with `phaseIn` on the next edge and leaves status bits 7:3 unchanged. The phase codes are 0 data-out, 1 data-in, 2 command, 3 status, 6 message-out and 7 message-in; 4 and 5 are reserved.
- R3: `raiseReq` sets status bit 7 and drives `irqOut` high on the next edge. A further raise while bit 7 is set changes nothing.
- R4: `reasonSet` bits are ORed into the reason byte. The reason bits are 3 function-complete, 4 bus-service, 5 disconnect and 7 bus-reset, and several may be set in one cycle.
- R5: A host read with `rdSel`=1 returns the reason byte in the same cycle. On the next edge the reason byte becomes 0, status bits 7, 6, 5 and 3 become 0 and `irqOut` goes low.
- R6: The terminal-count flag (status bit 4) and the phase field (status bits 2:0) keep their values across a reason read.
- R7: The sequence-step byte is not changed by a reason read.
- R8: When a set request and a reason read fall in the same cycle, the set request wins: the new reason bits, raise, flag or phase are present after the edge.
- R9: `irqOut` equals status bit 7 in every cycle.
- R10: `rdSel` chooses the byte on `rdData` (0 status, 1 reason, 2 sequence step, 3 configuration). Reads with `rdSel` other than 1 have no side effect.
- R11: `errSet[1]` sets status bit 6 and `errSet[0]` sets status bit 5. `tcSet` sets status bit 4 and `tcClr` clears it, with `tcSet` winning if both are asserted.
- R12: `cfgWe` loads `cfgIn` into the configuration byte, and `seqWe` loads `seqIn` into the sequence-step byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| phaseWe | input | 1 | Load the bus-phase field |
| phaseIn | input | 3 | New bus-phase code |
| raiseReq | input | 1 | Raise the interrupt |
| reasonSet | input | 8 | Reason bits to OR in |
| tcSet | input | 1 | Set the terminal-count flag |
| tcClr | input | 1 | Clear the terminal-count flag |
| errSet | input | 2 | Set the error flags (bit 1 gross error, bit 0 parity) |
| seqWe | input | 1 | Load the sequence-step byte |
| seqIn | input | 8 | New sequence-step value |
| cfgWe | input | 1 | Load the configuration byte |
| cfgIn | input | 8 | New configuration value |
| rdEn | input | 1 | Host read strobe |
| rdSel | input | 2 | Host read select |
| rdData | output | 8 | Selected byte, valid in the cycle of the read |
| irqOut | output | 1 | Level interrupt line |

## Verification
The hardest case to reach is a clearing reason read in the same cycle as new set requests. The returned value must be the old reasons, while the reasons, raise and phase presented in that cycle must survive the clear. The stimulus first builds a status byte with every flag set and several reasons pending. It then drives a reason read together with a raise, a bus-reset reason and a phase change in one cycle. Follow-up reads show that the set side won and that the terminal-count flag, the phase field and the sequence step came through the earlier read unchanged.

// File: rtl/irqstat_pkg.sv
package irqstat_pkg;
  localparam int BYTE_W  = 8;
  localparam int PHASE_W = 3;
  localparam int SEL_W   = 2;
  localparam int ERR_W   = 2;

  // status bit positions
  localparam int ST_INT   = 7;
  localparam int ST_GROSS = 6;
  localparam int ST_PAR   = 5;
  localparam int ST_TC    = 4;

  // bits that survive a reason read: terminal count and phase field
  localparam logic [BYTE_W-1:0] KEEP_ON_READ = 8'h17;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_REASON = 2'd1,
    SEL_SEQ    = 2'd2,
    SEL_CFG    = 2'd3
  } rdSelT;

  typedef struct packed {
    logic               clrOnRead;
    logic               raise;
    logic               phaseLoad;
    logic               tcUp;
    logic               tcDown;
    logic [ERR_W-1:0]   errUp;
    logic               seqLoad;
    logic               cfgLoad;
    logic [3:0]         rdOneHot;
  } strobeT;
endpackage

// File: rtl/irqstat_ctrl.sv
module irqstat_ctrl
  import irqstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phaseWe,
  input  logic             raiseReq,
  input  logic             tcSet,
  input  logic             tcClr,
  input  logic [ERR_W-1:0] errSet,
  input  logic             seqWe,
  input  logic             cfgWe,
  input  logic             rdEn,
  input  logic [SEL_W-1:0] rdSel,
  output strobeT           strobes
);
  always_comb begin
    strobes           = '0;
    strobes.clrOnRead = rdEn && (rdSel == SEL_REASON);
    strobes.raise     = raiseReq;
    strobes.phaseLoad = phaseWe;
    // set beats clear when both arrive together
    strobes.tcUp      = tcSet;
    strobes.tcDown    = tcClr && !tcSet;
    strobes.errUp     = errSet;
    strobes.seqLoad   = seqWe;
    strobes.cfgLoad   = cfgWe;
    for (int i = 0; i < 4; i++) begin
      strobes.rdOneHot[i] = (rdSel == SEL_W'(i));
    end
  end

  a_r11_tc_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.tcUp && strobes.tcDown));
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes.rdOneHot) && $countones(strobes.rdOneHot) == 1);
endmodule

// File: rtl/irqstat_datapath.sv
module irqstat_datapath
  import irqstat_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RESET = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobeT             strobes,
  input  logic [PHASE_W-1:0] phaseIn,
  input  logic [BYTE_W-1:0]  reasonSet,
  input  logic [BYTE_W-1:0]  seqIn,
  input  logic [BYTE_W-1:0]  cfgIn,
  output logic [BYTE_W-1:0]  rdData,
  output logic               irqOut
);
  logic [BYTE_W-1:0] statusQ, reasonQ, seqQ, cfgQ;
  logic [BYTE_W-1:0] statusN, reasonN;
  logic              irqQ;

  always_comb begin
    statusN = strobes.clrOnRead ? (statusQ & KEEP_ON_READ) : statusQ;
    if (strobes.tcDown) statusN[ST_TC] = 1'b0;
    if (strobes.tcUp)   statusN[ST_TC] = 1'b1;
    if (strobes.errUp[1]) statusN[ST_GROSS] = 1'b1;
    if (strobes.errUp[0]) statusN[ST_PAR]   = 1'b1;
    if (strobes.phaseLoad) statusN[PHASE_W-1:0] = phaseIn;
    if (strobes.raise) statusN[ST_INT] = 1'b1;
    reasonN = (strobes.clrOnRead ? '0 : reasonQ) | reasonSet;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ <= '0;
      reasonQ <= '0;
      seqQ    <= '0;
      cfgQ    <= CFG_RESET;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusN;
      reasonQ <= reasonN;
      irqQ    <= statusN[ST_INT];
      if (strobes.seqLoad) seqQ <= seqIn;
      if (strobes.cfgLoad) cfgQ <= cfgIn;
    end
  end

  always_comb begin
    unique case (1'b1)
      strobes.rdOneHot[SEL_REASON]: rdData = reasonQ;
      strobes.rdOneHot[SEL_SEQ]:    rdData = seqQ;
      strobes.rdOneHot[SEL_CFG]:    rdData = cfgQ;
      default:                      rdData = statusQ;
    endcase
  end

  assign irqOut = irqQ;

  a_r9_pin_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irqQ == statusQ[ST_INT]);
  a_r3_raise_sets_pin: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.raise |=> irqQ);
  a_r5_read_drops_pin: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrOnRead && !strobes.raise |=> !irqQ && reasonQ == $past(reasonSet));
  a_r6_tc_survives: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrOnRead && !strobes.tcUp && !strobes.tcDown && !strobes.phaseLoad
    |=> statusQ[ST_TC] == $past(statusQ[ST_TC]) && $stable(statusQ[PHASE_W-1:0]));
  a_r7_seq_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.seqLoad |=> $stable(seqQ));
  a_r2_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.phaseLoad && !strobes.clrOnRead && !strobes.raise && !strobes.tcUp
    && !strobes.tcDown && strobes.errUp == '0
    |=> statusQ[PHASE_W-1:0] == $past(phaseIn) && statusQ[7:3] == $past(statusQ[7:3]));
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import irqstat_pkg::*;
#(
  parameter logic [7:0] CFG_RESET = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phaseWe,
  input  logic [2:0] phaseIn,
  input  logic       raiseReq,
  input  logic [7:0] reasonSet,
  input  logic       tcSet,
  input  logic       tcClr,
  input  logic [1:0] errSet,
  input  logic       seqWe,
  input  logic [7:0] seqIn,
  input  logic       cfgWe,
  input  logic [7:0] cfgIn,
  input  logic       rdEn,
  input  logic [1:0] rdSel,
  output logic [7:0] rdData,
  output logic       irqOut
);
  strobeT strobes;

  irqstat_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .phaseWe(phaseWe), .raiseReq(raiseReq),
    .tcSet(tcSet), .tcClr(tcClr), .errSet(errSet), .seqWe(seqWe),
    .cfgWe(cfgWe), .rdEn(rdEn), .rdSel(rdSel), .strobes(strobes)
  );

  irqstat_datapath #(.CFG_RESET(CFG_RESET)) uData (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .phaseIn(phaseIn),
    .reasonSet(reasonSet), .seqIn(seqIn), .cfgIn(cfgIn),
    .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_scsi_irq_status.sv
`timescale 1ns/1ps
module tb_scsi_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phaseWe = 0, raiseReq = 0, tcSet = 0, tcClr = 0, seqWe = 0, cfgWe = 0, rdEn = 0;
  logic [2:0] phaseIn = 0;
  logic [7:0] reasonSet = 0, seqIn = 0, cfgIn = 0;
  logic [1:0] errSet = 0, rdSel = 0;
  logic [7:0] rdData;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } expT;
  expT q[$];

  always #2 clk = ~clk;

  scsi_irq_status dut (
    .clk(clk), .rst_n(rst_n), .phaseWe(phaseWe), .phaseIn(phaseIn),
    .raiseReq(raiseReq), .reasonSet(reasonSet), .tcSet(tcSet), .tcClr(tcClr),
    .errSet(errSet), .seqWe(seqWe), .seqIn(seqIn), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .irqOut(irqOut)
  );

  // monitor: compares every read against the oldest expectation
  always @(negedge clk) begin
    if (rdEn) begin
      expT e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL %s read with no expectation, actual %02h", "R10", rdData);
      end else begin
        e = q.pop_front();
        if (rdData !== e.exp) begin
          errors++;
          $display("FAIL %s actual %02h expected %02h", e.tag, rdData, e.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic hostRead(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    expT e;
    e.exp = exp; e.tag = tag;
    q.push_back(e);
    rdSel = sel; rdEn = 1;
    cyc();
    rdEn = 0;
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    checks++;
    if (irqOut !== exp) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irqOut, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R1 reset values
    hostRead(2'd0, 8'h00, "R1 status");
    hostRead(2'd1, 8'h00, "R1 reason");
    hostRead(2'd2, 8'h00, "R1 seq");
    hostRead(2'd3, 8'h07, "R1 cfg");
    checkIrq(1'b0, "R1");

    // R2 phase message-out
    phaseWe = 1; phaseIn = 3'd6; cyc(); phaseWe = 0;
    hostRead(2'd0, 8'h06, "R2 phase load");
    // R3 raise, then raise again
    raiseReq = 1; cyc(); raiseReq = 0;
    checkIrq(1'b1, "R3 raise");
    hostRead(2'd0, 8'h86, "R3 status int");
    raiseReq = 1; cyc(); raiseReq = 0;
    hostRead(2'd0, 8'h86, "R3 repeat raise");
    checkIrq(1'b1, "R9 pin follows flag");
    // R11 flags
    tcSet = 1; cyc(); tcSet = 0;
    errSet = 2'b11; cyc(); errSet = 0;
    hostRead(2'd0, 8'hF6, "R11 flags set");
    // R4 reasons, bus-service and function-complete together
    reasonSet = 8'h18; cyc(); reasonSet = 8'h20; cyc(); reasonSet = 0;
    hostRead(2'd1, 8'h38, "R4 reasons ORed");
    // the read above cleared; rebuild
    reasonSet = 8'h38; raiseReq = 1; errSet = 2'b11; cyc();
    reasonSet = 0; raiseReq = 0; errSet = 0;
    // R12 seq load
    seqWe = 1; seqIn = 8'h04; cyc(); seqWe = 0;
    hostRead(2'd2, 8'h04, "R12 seq load");
    // R2 phase data-in keeps high bits
    phaseWe = 1; phaseIn = 3'd1; cyc(); phaseWe = 0;
    hostRead(2'd0, 8'hF1, "R2 high bits kept");
    // R10 status/seq reads have no side effect
    hostRead(2'd0, 8'hF1, "R10 status reread");
    checkIrq(1'b1, "R10 no clear on status read");
    // R5 reason read
    hostRead(2'd1, 8'h38, "R5 reason read value");
    checkIrq(1'b0, "R5 pin dropped");
    hostRead(2'd1, 8'h00, "R5 reason cleared");
    hostRead(2'd0, 8'h11, "R6 tc and phase kept");
    hostRead(2'd2, 8'h04, "R7 seq kept");

    // R8 set wins over same-cycle read
    begin
      expT e;
      e.exp = 8'h00; e.tag = "R8 read returns old";
      q.push_back(e);
    end
    rdSel = 2'd1; rdEn = 1; raiseReq = 1; reasonSet = 8'h80; phaseWe = 1; phaseIn = 3'd7;
    cyc();
    rdEn = 0; raiseReq = 0; reasonSet = 0; phaseWe = 0;
    checkIrq(1'b1, "R8 raise survives");
    hostRead(2'd0, 8'h97, "R8 status after race");
    hostRead(2'd1, 8'h80, "R8 reason survives");
    hostRead(2'd0, 8'h17, "R6 after second read");
    checkIrq(1'b0, "R9 pin low");

    // R11 tc clear, and set wins over clear
    tcClr = 1; tcSet = 1; cyc(); tcClr = 0; tcSet = 0;
    hostRead(2'd0, 8'h17, "R11 set beats clear");
    tcClr = 1; cyc(); tcClr = 0;
    hostRead(2'd0, 8'h07, "R11 tc cleared");
    // R12 cfg write
    cfgWe = 1; cfgIn = 8'h5A; cyc(); cfgWe = 0;
    hostRead(2'd3, 8'h5A, "R12 cfg write");
    // R1 reset again
    rst_n = 0; cyc(); rst_n = 1; cyc();
    hostRead(2'd3, 8'h07, "R1 cfg after reset");
    hostRead(2'd0, 8'h00, "R1 status after reset");
    hostRead(2'd2, 8'h00, "R1 seq after reset");
    checkIrq(1'b0, "R1 pin after reset");

    cyc();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 unconsumed expectations actual %0d expected 0", q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule